// File: doc/BRIEF.md
# Bit Count and Parity Unit

This unit takes a 64-bit operand and returns one of several counts or parities derived from it. It computes leading-zero and trailing-zero counts over the lower 32-bit word or over the whole 64 bits. It computes population counts per byte lane, per 32-bit half or over all 64 bits. It computes byte-LSB parity per 32-bit half or over all 64 bits. For the zero-count operations a 4-bit condition field can be produced alongside the result. That field compares the result with zero and carries the caller's summary-overflow bit.

Operations enter on a valid/ready handshake and leave one cycle later through a single output register, which has its own valid/ready handshake. The input may accept a new operation in any cycle where the output register is empty or is being drained. When `out_valid` is high and `out_ready` is low, the output holds its values and `in_ready` is low, so no operation is lost and none is duplicated. Inside the unit, bit 0 is the least significant bit. "Lower word" means bits 31..0 and "byte k" means bits 8k+7..8k.

Top module: `bitcount_unit`

## Requirements
- R1: Operation code 0 returns the number of zero bits scanned from bit 31 downward before the first one bit, within bits 31..0 only. The result is 32 when those bits are all zero, and bits 63..32 of the operand are ignored.
- R2: Operation code 1 returns the number of zero bits scanned from bit 63 downward before the first one bit. The result is 64 for an all-zero operand.
- R3: Operation codes 2 and 3 return the number of zero bits scanned upward from bit 0 before the first one bit. Code 2 is limited to bits 31..0 with a maximum of 32, and code 3 has a maximum of 64. The count is zero-extended to 64 bits.
- R4: Operation code 4 writes the number of one bits of each byte lane k into the same lane k of the result.
- R5: Operation code 5 writes the one-bit count of bits 31..0 into result bits 31..0 and the one-bit count of bits 63..32 into result bits 63..32. Operation code 6 returns the one-bit count of all 64 bits.
- R6: Operation code 8 returns, in result bit 0, the XOR of bit 8k of the operand for k = 0..7. All other result bits are zero.
- R7: Operation code 7 places the XOR of bits 0, 8, 16 and 24 in result bit 0 and the XOR of bits 32, 40, 48 and 56 in result bit 32. All other result bits are zero.
- R8: `out_cr_we` is high exactly when the operation code is 0..3 and `in_rc` was high. In that case `out_cr` is {LT, GT, EQ, SO} from bit 3 down to bit 0, where LT/GT/EQ is the signed comparison of the result with zero and SO is the captured `in_so`. Otherwise `out_cr` is 0000.
- R9: Operation codes 9..15 return an all-zero result with `out_cr_we` low.
- R10: An accepted operation appears on the output in the cycle after acceptance. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_result`, `out_cr_we` and `out_cr` hold their values.
- R11: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when high with in_valid |
| in_op | input | 4 | Operation code |
| in_src | input | 64 | Source operand |
| in_rc | input | 1 | Request condition field for zero counts |
| in_so | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Operation result |
| out_cr_we | output | 1 | Condition field is meaningful |
| out_cr | output | 4 | {LT, GT, EQ, SO} |

## Verification
The cases hardest to reach from the ports are operands where the answer depends on a boundary bit. One example is a lower word that is zero while the upper word is not, which must still give 32 for the word zero counts. Another is a single one bit at position 31, 32 or 63. These are combined with a consumer that stalls while a new operation is waiting, so the output must hold. A directed sweep runs every operation code over such edge operands, with the condition request and SO bit toggled. After that, shifted random operands run with random gaps on both handshakes. A behavioural queue model is compared on every output transfer, and held values are checked on every stalled cycle.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int unsigned XW = 64;
  localparam int unsigned HW = XW / 2;

  typedef enum logic [3:0] {
    OP_CLZ_LO  = 4'd0,
    OP_CLZ_ALL = 4'd1,
    OP_CTZ_LO  = 4'd2,
    OP_CTZ_ALL = 4'd3,
    OP_POP_B   = 4'd4,
    OP_POP_H   = 4'd5,
    OP_POP_ALL = 4'd6,
    OP_PAR_H   = 4'd7,
    OP_PAR_ALL = 4'd8
  } bc_op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } bc_cr_t;
endpackage

// File: rtl/bc_zcount.sv
module bc_zcount #(
  parameter int unsigned W        = 64,
  parameter bit          TRAILING = 1'b0,
  localparam int unsigned CW      = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // ordered[W-1] is always the first bit examined
  logic [W-1:0] ordered;

  generate
    if (TRAILING) begin : g_rev
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign ordered[W-1-i] = vec[i];
      end
    end else begin : g_fwd
      assign ordered = vec;
    end
  endgenerate

  always_comb begin
    logic hit;
    hit = 1'b0;
    cnt = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (ordered[i]) hit = 1'b1;
        else            cnt = cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bc_popcount.sv
module bc_popcount #(
  parameter int unsigned W = 64,
  localparam int unsigned NB = W / 8,
  localparam int unsigned HW = W / 2,
  localparam int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  src,
  output logic [W-1:0]  lane_cnt,
  output logic [W-1:0]  half_cnt,
  output logic [CW-1:0] full_cnt
);
  logic [3:0] byte_n [NB];

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane
      always_comb begin
        byte_n[b] = '0;
        for (int j = 0; j < 8; j++) byte_n[b] = byte_n[b] + 4'(src[8*b+j]);
      end
      assign lane_cnt[8*b +: 8] = {4'b0, byte_n[b]};
    end
  endgenerate

  logic [CW-2:0] lo_n, hi_n;

  always_comb begin
    lo_n = '0;
    hi_n = '0;
    for (int b = 0; b < NB / 2; b++) begin
      lo_n = lo_n + (CW-1)'(byte_n[b]);
      hi_n = hi_n + (CW-1)'(byte_n[b + NB/2]);
    end
  end

  always_comb begin
    half_cnt = '0;
    half_cnt[CW-2:0]      = lo_n;
    half_cnt[HW +: CW-1]  = hi_n;
  end

  assign full_cnt = CW'(lo_n) + CW'(hi_n);
endmodule

// File: rtl/bc_parity.sv
module bc_parity #(
  parameter int unsigned W = 64,
  localparam int unsigned NB = W / 8,
  localparam int unsigned HW = W / 2
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] half_par,
  output logic [W-1:0] full_par
);
  logic [NB-1:0] lsbs;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lsb
      assign lsbs[b] = src[8*b];
    end
  endgenerate

  always_comb begin
    half_par         = '0;
    half_par[0]      = ^lsbs[NB/2-1:0];
    half_par[HW]     = ^lsbs[NB-1:NB/2];
    full_par         = '0;
    full_par[0]      = ^lsbs;
  end
endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
  import bc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [XW-1:0] in_src,
  input  logic          in_rc,
  input  logic          in_so,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_result,
  output logic          out_cr_we,
  output logic [3:0]    out_cr
);
  localparam int unsigned CWH = $clog2(HW) + 1;
  localparam int unsigned CWX = $clog2(XW) + 1;

  logic [CWH-1:0] clz_lo, ctz_lo;
  logic [CWX-1:0] clz_all, ctz_all, pop_all;
  logic [XW-1:0]  pop_lane, pop_half, par_half, par_all;

  bc_zcount #(.W(HW), .TRAILING(1'b0)) u_clz_lo  (.vec(in_src[HW-1:0]), .cnt(clz_lo));
  bc_zcount #(.W(XW), .TRAILING(1'b0)) u_clz_all (.vec(in_src),         .cnt(clz_all));
  bc_zcount #(.W(HW), .TRAILING(1'b1)) u_ctz_lo  (.vec(in_src[HW-1:0]), .cnt(ctz_lo));
  bc_zcount #(.W(XW), .TRAILING(1'b1)) u_ctz_all (.vec(in_src),         .cnt(ctz_all));

  bc_popcount #(.W(XW)) u_pop (
    .src(in_src), .lane_cnt(pop_lane), .half_cnt(pop_half), .full_cnt(pop_all)
  );

  bc_parity #(.W(XW)) u_par (.src(in_src), .half_par(par_half), .full_par(par_all));

  logic [XW-1:0] res_c;
  logic          zero_op;
  logic          cr_we_c;
  bc_cr_t        cr_c;

  always_comb begin
    res_c   = '0;
    zero_op = 1'b0;
    case (bc_op_e'(in_op))
      OP_CLZ_LO:  begin res_c[CWH-1:0] = clz_lo;  zero_op = 1'b1; end
      OP_CLZ_ALL: begin res_c[CWX-1:0] = clz_all; zero_op = 1'b1; end
      OP_CTZ_LO:  begin res_c[CWH-1:0] = ctz_lo;  zero_op = 1'b1; end
      OP_CTZ_ALL: begin res_c[CWX-1:0] = ctz_all; zero_op = 1'b1; end
      OP_POP_B:   res_c = pop_lane;
      OP_POP_H:   res_c = pop_half;
      OP_POP_ALL: res_c[CWX-1:0] = pop_all;
      OP_PAR_H:   res_c = par_half;
      OP_PAR_ALL: res_c = par_all;
      default:    res_c = '0;
    endcase
  end

  assign cr_we_c = zero_op && in_rc;

  always_comb begin
    cr_c = '0;
    if (cr_we_c) begin
      cr_c.lt = res_c[XW-1];
      cr_c.gt = !res_c[XW-1] && (res_c != '0);
      cr_c.eq = (res_c == '0);
      cr_c.so = in_so;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cr_we  <= 1'b0;
      out_cr     <= '0;
    end else begin
      if (in_valid && in_ready) begin
        out_valid  <= 1'b1;
        out_result <= res_c;
        out_cr_we  <= cr_we_c;
        out_cr     <= cr_c;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  // R1
  clz_lo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clz_lo <= CWH'(HW));

  // R5
  pop_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_all == CWX'(pop_half[CWH-1:0]) + CWX'(pop_half[HW +: CWH]));

  // R8
  cr_lt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_we |-> !out_cr[3]);

  // R8
  cr_eq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_we |-> (out_cr[1] == (out_result == '0)));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cr) && $stable(out_cr_we));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/tb_bitcount_unit.sv
`timescale 1ns/1ps
module tb_bitcount_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_rc, in_so;
  logic [3:0]  in_op;
  logic [63:0] in_src;
  logic        out_valid, out_ready, out_cr_we;
  logic [63:0] out_result;
  logic [3:0]  out_cr;

  always #4 clk = ~clk;

  bitcount_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_rc(in_rc), .in_so(in_so),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_cr_we(out_cr_we), .out_cr(out_cr)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] res;
    logic        we;
    logic [3:0]  cr;
  } exp_t;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  function automatic string tag(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R7";
      4'd8: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(logic [3:0] op, logic [63:0] s, logic rc, logic so);
    exp_t e;
    int n;
    e.op = op; e.res = '0; e.we = 1'b0; e.cr = '0;
    n = 0;
    case (op)
      4'd0: begin while (n < 32 && s[31-n] == 1'b0) n++; e.res = 64'(n); e.we = rc; end
      4'd1: begin while (n < 64 && s[63-n] == 1'b0) n++; e.res = 64'(n); e.we = rc; end
      4'd2: begin while (n < 32 && s[n] == 1'b0) n++; e.res = 64'(n); e.we = rc; end
      4'd3: begin while (n < 64 && s[n] == 1'b0) n++; e.res = 64'(n); e.we = rc; end
      4'd4: for (int b = 0; b < 8; b++) begin
              n = 0;
              for (int j = 0; j < 8; j++) n += int'(s[8*b+j]);
              e.res[8*b +: 8] = 8'(n);
            end
      4'd5: for (int h = 0; h < 2; h++) begin
              n = 0;
              for (int j = 0; j < 32; j++) n += int'(s[32*h+j]);
              e.res[32*h +: 32] = 32'(n);
            end
      4'd6: begin for (int j = 0; j < 64; j++) n += int'(s[j]); e.res = 64'(n); end
      4'd7: begin
              e.res[0]  = s[0] ^ s[8] ^ s[16] ^ s[24];
              e.res[32] = s[32] ^ s[40] ^ s[48] ^ s[56];
            end
      4'd8: for (int b = 0; b < 8; b++) e.res[0] = e.res[0] ^ s[8*b];
      default: ;
    endcase
    if (e.we) e.cr = {$signed(e.res) < 0, $signed(e.res) > 0, e.res == 64'd0, so};
    return e;
  endfunction

  function automatic logic [63:0] edge_src(int k);
    case (k)
      0: return 64'h0;
      1: return '1;
      2: return 64'h1;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h0000_0001_0000_0000;
      5: return 64'h0000_0000_8000_0000;
      default: return 64'h0101_0001_0100_0100;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    localparam int NDIR = 16 * 7;
    localparam int TOTAL = NDIR + 3000;
    int sent;
    bit have;
    bit held;
    logic [63:0] held_res;
    logic [3:0]  cur_op;
    logic [63:0] cur_src;
    logic        cur_rc, cur_so;
    exp_t e;

    sent = 0; have = 0; held = 0; held_res = '0;
    cur_op = '0; cur_src = '0; cur_rc = 0; cur_so = 0;
    rst_n = 1'b0; in_valid = 0; in_op = '0; in_src = '0; in_rc = 0; in_so = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 20000 && !(sent >= TOTAL && q.size() == 0); cyc++) begin
      @(negedge clk);
      if (held) begin
        checks++;
        if (out_valid !== 1'b1 || out_result !== held_res) begin
          errors++;
          $display("FAIL R10: stalled output changed, actual %b %h expected 1 %h",
                   out_valid, out_result, held_res);
        end
      end
      if (!have && sent < TOTAL) begin
        if (sent < NDIR) begin
          cur_op  = 4'(sent % 16);
          cur_src = edge_src(sent / 16);
          cur_rc  = sent[0] ^ sent[4];
          cur_so  = sent[1];
        end else begin
          cur_op  = 4'($urandom % 16);
          cur_src = {$urandom, $urandom} >> ($urandom % 64);
          if ($urandom % 3 == 0) cur_src = cur_src << ($urandom % 64);
          cur_rc  = 1'($urandom);
          cur_so  = 1'($urandom);
        end
        have = 1;
      end
      in_valid  = have && ($urandom % 5 != 0);
      in_op     = cur_op;
      in_src    = cur_src;
      in_rc     = cur_rc;
      in_so     = cur_so;
      out_ready = (sent < NDIR) ? 1'b1 : ($urandom % 4 != 0);
      #1;
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        errors++;
        $display("FAIL R10: in_ready=%b expected %b", in_ready, !out_valid || out_ready);
      end
      held = out_valid && !out_ready;
      held_res = out_result;
      if (out_valid && out_ready) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R10: output valid with nothing accepted, actual %h expected none", out_result);
        end else begin
          e = q.pop_front();
          if (out_result !== e.res || out_cr_we !== e.we || out_cr !== e.cr) begin
            errors++;
            $display("FAIL %s: op %0d actual res=%h we=%b cr=%b expected res=%h we=%b cr=%b (R8)",
                     tag(e.op), e.op, out_result, out_cr_we, out_cr, e.res, e.we, e.cr);
          end
        end
      end
      if (in_valid && in_ready) begin
        q.push_back(model(cur_op, cur_src, cur_rc, cur_so));
        have = 0;
        sent++;
      end
    end

    checks++;
    if (q.size() != 0 || sent < TOTAL) begin
      errors++;
      $display("FAIL R10: items outstanding actual %0d sent %0d expected 0 and %0d", q.size(), sent, TOTAL);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule